// File: doc/BRIEF.md
# SD Card Response Frame Receiver

This block sits in a host controller beside the command transmitter. The controller issues a command, pulses `start_req` with the expected response kind, and the receiver then watches the command line. The line is sampled once per `bit_en` pulse, most significant bit first. Idle ones are skipped until the first zero, which is the start bit. From there the block gathers either a 48-bit short frame or a 136-bit long frame that carries a card register.

When the last bit arrives, the receiver checks the fixed framing bits in that same cycle. It also checks the CRC7 where the response kind carries a real one. It then raises `done` for one cycle and holds the decoded fields: command index, 32-bit argument field (card status or operating-conditions word), relative card address, and the 127-bit register payload. Error flags for CRC, end bit, transmission bit, fixed-field mismatch and timeout stay set until the next request. For the busy-capable status kind, `busy_chk` tells the host logic to poll the data line for busy.

Top module: `sd_resp_rx`

## Requirements
- R1: After `start_req`, ones sampled on `bit_en` are ignored. The first zero sampled is the start bit, which is frame bit 0 counted from the most significant end.
- R2: `resp_type` 0 (status), 1 (status with busy), 3 (operating conditions) and 4 (address) select a 48-bit frame. The cycle after the 48th bit is taken, `done` is 1, `cmd_idx` equals frame bits 45:40 and `arg_field` equals frame bits 39:8.
- R3: `resp_type` 2 selects a 136-bit frame. Bits 133:128 must be 111111, or else `err_fixed` is set. `reg_payload` equals frame bits 127:1.
- R4: The transmission bit (bit 46 of a short frame, bit 134 of a long frame) must be 0, or else `err_tx` is set.
- R5: Bit 0 of every frame must be 1, or else `err_end` is set.
- R6: For types 0, 1 and 4, a CRC7 with polynomial x^7+x^3+1 and zero initial value is computed over bits 47:8. If it differs from bits 7:1, `err_crc` is set.
- R7: For type 3 no CRC check is made. Bits 45:40 must be 111111 and bits 7:1 must be 1111111, or else `err_fixed` is set.
- R8: For type 4, `rca` equals frame bits 39:24. An index other than 000011 sets `err_fixed`.
- R9: For type 1, `busy_chk` is 1 in the same cycle as `done`. It is 0 for every other type and for a timeout.
- R10: If 64 `bit_en` pulses carry ones after a request, `err_timeout` and `done` go to 1 in the following cycle. A start bit on the 64th pulse is still accepted.
- R11: `done` lasts one cycle. The error flags stay set until the next `start_req`, and are 0 in the cycle after it.
- R12: Cycles with `bit_en` low change nothing, whatever `cmd_in` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Arm the receiver for a new response and clear the flags |
| resp_type | input | 3 | Expected response kind (0 status, 1 status+busy, 2 long register, 3 operating conditions, 4 address) |
| bit_en | input | 1 | Line-bit sample enable |
| cmd_in | input | 1 | Serial command line |
| done | output | 1 | One-cycle end-of-response pulse |
| busy_chk | output | 1 | Request to check the data line for busy |
| cmd_idx | output | 6 | Index field of a short frame |
| arg_field | output | 32 | Card status or operating-conditions word |
| rca | output | 16 | Published relative card address |
| reg_payload | output | 127 | Long-frame register bits 127..1 |
| err_crc | output | 1 | CRC7 mismatch |
| err_end | output | 1 | End bit was 0 |
| err_tx | output | 1 | Transmission bit was 1 |
| err_fixed | output | 1 | Reserved or fixed field mismatch |
| err_timeout | output | 1 | No start bit within the window |

## Verification
The hardest case to reach is the timeout window boundary. A start bit on exactly the 64th enable pulse must still open a frame, while 64 ones must end the wait. The bench drives exactly 63 idle ones before a good frame, and exactly 64 with no frame. Enable gaps during which `cmd_in` is pulled low are spread through frames, so a receiver that samples without its enable would see false start bits and broken frames.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int CRC_SPAN  = 40;
  localparam logic [6:0] CRC_POLY = 7'h09;

  typedef enum logic [2:0] {
    RT_STATUS      = 3'd0,
    RT_STATUS_BUSY = 3'd1,
    RT_LONG_REG    = 3'd2,
    RT_OPCOND      = 3'd3,
    RT_ADDR        = 3'd4
  } rtype_e;
endpackage

// File: rtl/sd_resp_crc7.sv
module sd_resp_crc7 #(
  parameter logic [6:0] POLY = 7'h09
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic       din,
  output logic [6:0] crc
);
  logic [6:0] crc_q, crc_d;
  logic       fb;

  always_comb begin
    fb    = din ^ crc_q[6];
    crc_d = crc_q;
    if (clr)      crc_d = '0;
    else if (upd) crc_d = {crc_q[5:0], 1'b0} ^ (fb ? POLY : 7'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sd_resp_seq.sv
module sd_resp_seq #(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int CRC_SPAN  = 40,
  parameter int TMO       = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic bit_en,
  input  logic cmd_in,
  input  logic long_frame,
  output logic take_bit,
  output logic crc_upd,
  output logic last_bit,
  output logic tmo_hit
);
  localparam int CNT_W = $clog2(LONG_LEN);
  localparam int TMO_W = $clog2(TMO + 1);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_COLLECT} st_e;

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, last_val;
  logic [TMO_W-1:0] wait_q, wait_d;

  always_comb begin
    last_val = long_frame ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);
    take_bit = !start_req && bit_en &&
               ((st_q == S_HUNT && !cmd_in) || st_q == S_COLLECT);
    crc_upd  = take_bit && (cnt_q < CNT_W'(CRC_SPAN));
    last_bit = !start_req && bit_en && st_q == S_COLLECT && cnt_q == last_val;
    tmo_hit  = !start_req && bit_en && cmd_in && st_q == S_HUNT &&
               wait_q == TMO_W'(TMO - 1);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wait_d = wait_q;
    if (start_req) begin
      st_d   = S_HUNT;
      cnt_d  = '0;
      wait_d = '0;
    end else if (bit_en) begin
      case (st_q)
        S_HUNT: begin
          if (!cmd_in) begin
            st_d  = S_COLLECT;
            cnt_d = CNT_W'(1);
          end else if (tmo_hit) begin
            st_d = S_IDLE;
          end else begin
            wait_d = wait_q + TMO_W'(1);
          end
        end
        S_COLLECT: begin
          if (last_bit) st_d = S_IDLE;
          else          cnt_d = cnt_q + CNT_W'(1);
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
    end
  end

  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({last_bit, tmo_hit}));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(LONG_LEN));
endmodule

// File: rtl/sd_resp_rx.sv
module sd_resp_rx
  import sd_resp_pkg::*;
#(
  parameter int TIMEOUT_PULSES = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_req,
  input  logic [2:0]   resp_type,
  input  logic         bit_en,
  input  logic         cmd_in,
  output logic         done,
  output logic         busy_chk,
  output logic [5:0]   cmd_idx,
  output logic [31:0]  arg_field,
  output logic [15:0]  rca,
  output logic [126:0] reg_payload,
  output logic         err_crc,
  output logic         err_end,
  output logic         err_tx,
  output logic         err_fixed,
  output logic         err_timeout
);
  localparam int SH_W = LONG_LEN - 2;

  logic [2:0]      rtype_q, rtype_d;
  logic [SH_W-1:0] shift_q, shift_d;
  logic [SH_W:0]   nx;
  logic [6:0]      crc;
  logic            take_bit, crc_upd, last_bit, tmo_hit;
  logic            is_long, is_opc, is_addr, is_busy;
  logic            chk_crc, chk_end, chk_tx, chk_fixed;
  logic            done_q, busy_q, e_crc_q, e_end_q, e_tx_q, e_fix_q, e_tmo_q;
  logic            done_d, busy_d, e_crc_d, e_end_d, e_tx_d, e_fix_d, e_tmo_d;

  assign is_long = rtype_q == RT_LONG_REG;
  assign is_opc  = rtype_q == RT_OPCOND;
  assign is_addr = rtype_q == RT_ADDR;
  assign is_busy = rtype_q == RT_STATUS_BUSY;

  sd_resp_seq #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .CRC_SPAN(CRC_SPAN), .TMO(TIMEOUT_PULSES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .bit_en(bit_en),
    .cmd_in(cmd_in), .long_frame(is_long), .take_bit(take_bit),
    .crc_upd(crc_upd), .last_bit(last_bit), .tmo_hit(tmo_hit)
  );

  sd_resp_crc7 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start_req), .upd(crc_upd),
    .din(cmd_in), .crc(crc)
  );

  assign nx = {shift_q, cmd_in};

  always_comb begin
    chk_tx    = is_long ? nx[134] : nx[46];
    chk_end   = !nx[0];
    chk_crc   = !is_long && !is_opc && (nx[7:1] != crc);
    chk_fixed = 1'b0;
    if (is_long)      chk_fixed = nx[133:128] != 6'h3F;
    else if (is_opc)  chk_fixed = (nx[45:40] != 6'h3F) || (nx[7:1] != 7'h7F);
    else if (is_addr) chk_fixed = nx[45:40] != 6'd3;
  end

  always_comb begin
    rtype_d = rtype_q;
    shift_d = shift_q;
    done_d  = last_bit | tmo_hit;
    busy_d  = last_bit & is_busy;
    e_crc_d = e_crc_q;
    e_end_d = e_end_q;
    e_tx_d  = e_tx_q;
    e_fix_d = e_fix_q;
    e_tmo_d = e_tmo_q;
    if (start_req) begin
      rtype_d = resp_type;
      shift_d = '0;
      e_crc_d = 1'b0;
      e_end_d = 1'b0;
      e_tx_d  = 1'b0;
      e_fix_d = 1'b0;
      e_tmo_d = 1'b0;
    end else begin
      if (take_bit) shift_d = nx[SH_W-1:0];
      if (last_bit) begin
        e_crc_d = chk_crc;
        e_end_d = chk_end;
        e_tx_d  = chk_tx;
        e_fix_d = chk_fixed;
      end
      if (tmo_hit) e_tmo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtype_q <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
      e_crc_q <= 1'b0;
      e_end_q <= 1'b0;
      e_tx_q  <= 1'b0;
      e_fix_q <= 1'b0;
      e_tmo_q <= 1'b0;
    end else begin
      rtype_q <= rtype_d;
      shift_q <= shift_d;
      done_q  <= done_d;
      busy_q  <= busy_d;
      e_crc_q <= e_crc_d;
      e_end_q <= e_end_d;
      e_tx_q  <= e_tx_d;
      e_fix_q <= e_fix_d;
      e_tmo_q <= e_tmo_d;
    end
  end

  assign done        = done_q;
  assign busy_chk    = busy_q;
  assign cmd_idx     = shift_q[45:40];
  assign arg_field   = shift_q[39:8];
  assign rca         = shift_q[39:24];
  assign reg_payload = shift_q[127:1];
  assign err_crc     = e_crc_q;
  assign err_end     = e_end_q;
  assign err_tx      = e_tx_q;
  assign err_fixed   = e_fix_q;
  assign err_timeout = e_tmo_q;

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !(err_crc | err_end | err_tx | err_fixed | err_timeout | done));
  assert_busy_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_chk |-> done && !err_timeout);
  assert_timeout_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> done);
  assert_opcond_nocrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_opc) |-> !err_crc);
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !start_req) |=> $stable(shift_q));
endmodule

// File: tb/sd_resp_rx_bench.sv
module sd_resp_rx_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_req = 1'b0;
  logic [2:0]   resp_type = 3'd0;
  logic         bit_en = 1'b0;
  logic         cmd_in = 1'b1;
  logic         done, busy_chk;
  logic [5:0]   cmd_idx;
  logic [31:0]  arg_field;
  logic [15:0]  rca;
  logic [126:0] reg_payload;
  logic         err_crc, err_end, err_tx, err_fixed, err_timeout;

  int checks = 0;
  int errors = 0;
  logic exp_done = 1'b0;
  logic exp_busy = 1'b0;
  bit   mon_on = 1'b0;

  always #2 clk = ~clk;

  sd_resp_rx u_sd_resp_rx (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .resp_type(resp_type),
    .bit_en(bit_en), .cmd_in(cmd_in), .done(done), .busy_chk(busy_chk),
    .cmd_idx(cmd_idx), .arg_field(arg_field), .rca(rca),
    .reg_payload(reg_payload), .err_crc(err_crc), .err_end(err_end),
    .err_tx(err_tx), .err_fixed(err_fixed), .err_timeout(err_timeout)
  );

  function automatic logic [6:0] crc7f(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = 7'h00;
    for (int i = hi; i >= lo; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [135:0] mk_short(input logic tx, input logic [5:0] idx,
                                            input logic [31:0] arg);
    logic [135:0] f = {88'h0, 1'b0, tx, idx, arg, 7'h00, 1'b1};
    f[7:1] = crc7f(f, 47, 8);
    return f;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic [4:0] exp);
    chk(tag, {123'h0, err_crc, err_end, err_tx, err_fixed, err_timeout}, {123'h0, exp});
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL R11 done per-cycle actual=%b expected=%b", done, exp_done);
      end
      checks++;
      if (busy_chk !== exp_busy) begin
        errors++;
        $display("FAIL R9 busy_chk per-cycle actual=%b expected=%b", busy_chk, exp_busy);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Issue a request, idle ones, then the frame; leaves the bench in the done cycle.
  task automatic run(input logic [2:0] typ, input logic [135:0] fr, input int len,
                     input int idle, input int gap);
    start_req = 1'b1; resp_type = typ; bit_en = 1'b0; cmd_in = 1'b1;
    step();
    start_req = 1'b0;
    chk_flags("R11 flags cleared after request", 5'b00000);
    for (int i = 0; i < idle; i++) begin
      bit_en = 1'b1; cmd_in = 1'b1;
      step();
      if (len > 0 || i < idle - 1)
        for (int g = 0; g < gap; g++) begin bit_en = 1'b0; cmd_in = 1'b0; step(); end
    end
    for (int i = len - 1; i >= 0; i--) begin
      bit_en = 1'b1; cmd_in = fr[i];
      step();
      if (i > 0)
        for (int g = 0; g < gap; g++) begin bit_en = 1'b0; cmd_in = 1'b0; step(); end
    end
    bit_en = 1'b0; cmd_in = 1'b1;
    exp_done = 1'b1;
    exp_busy = (len > 0) && (typ == 3'd1);
  endtask

  task automatic finish_frame();
    step();
    exp_done = 1'b0;
    exp_busy = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [135:0] fr;
    logic [126:0] pay;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset done", {127'h0, done}, 128'h0);
    chk_flags("R11 reset flags", 5'b00000);
    rst_n = 1'b1;
    step();
    mon_on = 1'b1;

    // R2 R6 R1: good status frame after idle ones
    fr = mk_short(1'b0, 6'd17, 32'hDEAD_BEEF);
    run(3'd0, fr, 48, 5, 0);
    chk("R2 cmd_idx", {122'h0, cmd_idx}, 128'd17);
    chk("R2 arg_field", {96'h0, arg_field}, {96'h0, 32'hDEAD_BEEF});
    chk_flags("R1 R6 good frame flags", 5'b00000);
    finish_frame();
    chk("R11 done falls", {127'h0, done}, 128'h0);
    chk_flags("R11 flags persist (none)", 5'b00000);

    // R9 busy kind, with enable gaps carrying zeros (R12)
    fr = mk_short(1'b0, 6'd7, 32'h0000_0900);
    run(3'd1, fr, 48, 2, 3);
    chk("R12 arg through gaps", {96'h0, arg_field}, {96'h0, 32'h0000_0900});
    chk("R12 idx through gaps", {122'h0, cmd_idx}, 128'd7);
    chk_flags("R9 busy frame flags", 5'b00000);
    finish_frame();

    // R6 crc corruption
    fr = mk_short(1'b0, 6'd13, 32'h1234_5678);
    fr[3] = ~fr[3];
    run(3'd0, fr, 48, 0, 1);
    chk_flags("R6 crc error", 5'b10000);
    finish_frame();
    repeat (3) step();
    chk_flags("R11 crc flag sticky", 5'b10000);

    // R4 transmission bit set, crc valid over it
    fr = mk_short(1'b1, 6'd13, 32'h0F0F_0F0F);
    run(3'd0, fr, 48, 1, 0);
    chk_flags("R4 tx bit error", 5'b00100);
    finish_frame();

    // R5 end bit zero
    fr = mk_short(1'b0, 6'd55, 32'hA5A5_5A5A);
    fr[0] = 1'b0;
    run(3'd1, fr, 48, 0, 0);
    chk_flags("R5 end bit error", 5'b01000);
    finish_frame();

    // R7 operating-conditions frame: all-ones index and crc, no crc check
    fr = {88'h0, 1'b0, 1'b0, 6'h3F, 32'h80FF_8000, 7'h7F, 1'b1};
    run(3'd3, fr, 48, 4, 1);
    chk("R7 ocr word", {96'h0, arg_field}, {96'h0, 32'h80FF_8000});
    chk_flags("R7 no crc check", 5'b00000);
    finish_frame();
    fr[41] = 1'b0;
    run(3'd3, fr, 48, 0, 0);
    chk_flags("R7 index field mismatch", 5'b00010);
    finish_frame();
    fr = {88'h0, 1'b0, 1'b0, 6'h3F, 32'h80FF_8000, 7'h3F, 1'b1};
    run(3'd3, fr, 48, 0, 0);
    chk_flags("R7 crc field mismatch", 5'b00010);
    finish_frame();

    // R8 address frame
    fr = mk_short(1'b0, 6'd3, 32'hB00C_0520);
    run(3'd4, fr, 48, 3, 0);
    chk("R8 rca", {112'h0, rca}, {112'h0, 16'hB00C});
    chk_flags("R8 good address frame", 5'b00000);
    finish_frame();
    fr = mk_short(1'b0, 6'd5, 32'hB00C_0520);
    run(3'd4, fr, 48, 0, 0);
    chk_flags("R8 wrong index", 5'b00010);
    finish_frame();

    // R3 long register frame
    pay = {31'h1357_9BDF, 32'h2468_ACE0, 32'hFEDC_BA98, 32'h0F1E_2D3C};
    fr = {1'b0, 1'b0, 6'h3F, pay, 1'b1};
    run(3'd2, fr, 136, 2, 1);
    chk("R3 payload", {1'b0, reg_payload}, {1'b0, pay});
    chk_flags("R3 good long frame", 5'b00000);
    finish_frame();
    fr[130] = 1'b0;
    run(3'd2, fr, 136, 0, 0);
    chk_flags("R3 reserved header mismatch", 5'b00010);
    finish_frame();
    fr = {1'b0, 1'b1, 6'h3F, pay, 1'b0};
    run(3'd2, fr, 136, 0, 0);
    chk_flags("R4 R5 long tx and end errors", 5'b01100);
    finish_frame();

    // R10 boundary: start bit on the 64th pulse accepted
    fr = mk_short(1'b0, 6'd42, 32'h7777_0001);
    run(3'd0, fr, 48, 63, 0);
    chk_flags("R10 start on last pulse", 5'b00000);
    chk("R10 idx after long wait", {122'h0, cmd_idx}, 128'd42);
    finish_frame();

    // R10 timeout after 64 ones
    run(3'd1, 136'h0, 0, 64, 0);
    chk_flags("R10 timeout", 5'b00001);
    finish_frame();
    repeat (4) begin bit_en = 1'b1; cmd_in = 1'b0; step(); end
    bit_en = 1'b0;
    chk_flags("R10 timeout sticky, late zeros ignored", 5'b00001);

    // R11 request clears flags
    start_req = 1'b1; resp_type = 3'd0;
    step();
    start_req = 1'b0;
    chk_flags("R11 request clears timeout", 5'b00000);
    repeat (3) step();

    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule